// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small serial memory. It oversamples the two bus wires (serial clock and serial data) with the system clock and finds the start and stop conditions on them. It shifts in the slave address byte, compares it with a fixed device type and two strap pins, and acknowledges. It then walks the transaction: a word address byte and data bytes in write mode, or outgoing data bytes in read mode. The only drive onto the data wire is an open-drain pull-down enable.

The memory array sits outside the block and sees only single-cycle strobes. One marks an accepted slave address, with its read/write bit and memory address extension bit. Others mark a received word address and each received data byte, with the byte itself. One requests the next read byte, and one marks the stop that ends a selected transaction. A busy input, held by the memory during its internal write, makes the block ignore its own address. A master can therefore poll for the end of the write by watching for the acknowledge.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the pull-down enable is low and no strobe is active.
- R2: Bus clocking before any start condition (SDA falling while SCL high) is ignored: no acknowledge and no strobe.
- R3: An address byte, MSB first, with bits [7:4] = 4'b1010 and bits [3:2] equal to strap_i[1:0] is acknowledged by pulling SDA low during the ninth SCL pulse. addr_stb_o pulses once. page_o takes bit [1], and rnw_o takes bit [0] (1 = read, 0 = write).
- R4: An address byte whose type or strap bits differ gets no acknowledge. No later byte is acknowledged until the next start.
- R5: While busy_i is high when the address is decided, the address is not acknowledged and addr_stb_o stays low.
- R6: In write mode the first following byte is acknowledged and reported with word_stb_o. Each later byte is acknowledged and reported with data_stb_o. rx_byte_o holds the byte during and after its strobe.
- R7: In read mode rd_req_o pulses at the ninth SCL rising edge before each byte. rd_data_i must be valid from the next clock until the following SCL falling edge. The byte is then sent MSB first, each bit changed only after an SCL falling edge.
- R8: After a read byte, the block sends the next byte only if the master pulls SDA low on the ninth pulse. Without that acknowledge it releases SDA and makes no further request until a start or stop.
- R9: A repeated start after the word address byte begins a new address phase, so a write address followed by a read address performs a random read.
- R10: A stop condition (SDA rising while SCL high) returns the block to idle, releases SDA, and pulses stop_o only if the transaction's address was acknowledged.
- R11: The pull-down enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock wire level |
| sda_i | input | 1 | Serial data wire level |
| sda_oe_o | output | 1 | 1 pulls the data wire low |
| strap_i | input | 2 | Device select straps, [1] matches address bit 3, [0] bit 2 |
| busy_i | input | 1 | Internal write in progress; address not acknowledged |
| rd_data_i | input | 8 | Byte to transmit, supplied after rd_req_o |
| addr_stb_o | output | 1 | Own address accepted |
| page_o | output | 1 | Memory address extension bit from the address byte |
| rnw_o | output | 1 | Direction of the accepted transaction, 1 = read |
| word_stb_o | output | 1 | Word address byte received |
| data_stb_o | output | 1 | Write data byte received |
| rx_byte_o | output | 8 | Last received word address or data byte |
| rd_req_o | output | 1 | Next read byte requested |
| stop_o | output | 1 | Stop ended a selected transaction |

## Verification
A wrong phase or bit count shows on the bus within one byte time. The acknowledge appears on the wrong pulse or not at all, or a read byte comes out shifted by one bit position. A wrong selection flag shows up as a missing or extra strobe at the next byte boundary, or as a stop pulse after an ignored address. Each scenario samples the data wire in the middle of every SCL high phase and compares strobe counts after each byte, so a fault is caught in the byte where it occurs.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WORD,
        PH_WDATA,
        PH_RDATA,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  rx;
        logic               oe;
        logic               sel;
        logic               rnw;
        logic               page;
        logic               mack;
        logic               addr_stb;
        logic               word_stb;
        logic               data_stb;
        logic               rd_req;
        logic               stop;
    } slv_state_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic scl_prev_q, sda_prev_q;
    logic scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match
    import tw_pkg::*;
(
    input  logic [5:0] id_bits,
    input  logic [1:0] strap_i,
    input  logic       busy_i,
    output logic       hit
);
    assign hit = (id_bits[5:2] == DEV_TYPE) && (id_bits[1:0] == strap_i) && !busy_i;
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              addr_stb_o,
    output logic              page_o,
    output logic              rnw_o,
    output logic              word_stb_o,
    output logic              data_stb_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rd_req_o,
    output logic              stop_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det, hit;
    slv_state_t q, d;

    tw_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tw_addr_match i_match (
        .id_bits(q.sh[7:2]), .strap_i(strap_i), .busy_i(busy_i), .hit(hit)
    );

    always_comb begin
        d          = q;
        d.addr_stb = 1'b0;
        d.word_stb = 1'b0;
        d.data_stb = 1'b0;
        d.rd_req   = 1'b0;
        d.stop     = 1'b0;
        if (stop_det) begin
            d.stop = q.sel;
            d.ph   = PH_IDLE;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.sel  = 1'b0;
        end else if (start_det) begin
            d.ph  = PH_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.sel = 1'b0;
        end else begin
            case (q.ph)
                PH_ADDR, PH_WORD, PH_WDATA: begin
                    if (scl_rise) begin
                        if (q.cnt < LAST_BIT) begin
                            d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                            d.cnt = q.cnt + 1'b1;
                        end else begin
                            d.cnt = ACK_BIT;
                            if (q.ph == PH_ADDR && q.sel && q.rnw) d.rd_req = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            if (q.ph == PH_ADDR) begin
                                if (hit) begin
                                    d.oe       = 1'b1;
                                    d.sel      = 1'b1;
                                    d.rnw      = q.sh[0];
                                    d.page     = q.sh[1];
                                    d.addr_stb = 1'b1;
                                end else begin
                                    d.ph = PH_WAIT;
                                end
                            end else begin
                                d.oe = 1'b1;
                                d.rx = q.sh;
                                if (q.ph == PH_WORD) d.word_stb = 1'b1;
                                else                 d.data_stb = 1'b1;
                            end
                        end else if (q.cnt == ACK_BIT) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            if (q.ph == PH_ADDR) begin
                                if (q.rnw) begin
                                    d.ph = PH_RDATA;
                                    d.sh = rd_data_i;
                                    d.oe = ~rd_data_i[BYTE_W-1];
                                end else begin
                                    d.ph = PH_WORD;
                                end
                            end else begin
                                d.ph = PH_WDATA;
                            end
                        end
                    end
                end
                PH_RDATA: begin
                    if (scl_rise) begin
                        if (q.cnt < LAST_BIT) begin
                            d.cnt = q.cnt + 1'b1;
                        end else begin
                            d.cnt  = ACK_BIT;
                            d.mack = ~sda_s;
                            d.rd_req = ~sda_s;
                        end
                    end else if (scl_fall) begin
                        if (q.cnt != '0 && q.cnt < LAST_BIT) begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end else if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                        end else if (q.cnt == ACK_BIT) begin
                            d.cnt = '0;
                            if (q.mack) begin
                                d.sh = rd_data_i;
                                d.oe = ~rd_data_i[BYTE_W-1];
                            end else begin
                                d.ph = PH_WAIT;
                                d.oe = 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign addr_stb_o = q.addr_stb;
    assign page_o     = q.page;
    assign rnw_o      = q.rnw;
    assign word_stb_o = q.word_stb;
    assign data_stb_o = q.data_stb;
    assign rx_byte_o  = q.rx;
    assign rd_req_o   = q.rd_req;
    assign stop_o     = q.stop;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic busy_i,
    input logic addr_stb_o,
    input logic word_stb_o,
    input logic data_stb_o,
    input logic rnw_o,
    input logic rd_req_o,
    input logic stop_o
);
    // R11
    oe_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R5
    busy_blocks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_o |-> !$past(busy_i));

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_stb_o, word_stb_o, data_stb_o}));

    // R3
    addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_o |=> !addr_stb_o);

    // R7
    req_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rnw_o);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !sda_oe_o);
endmodule

bind tw_mem_slave tw_mem_slave_chk i_tw_mem_slave_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .busy_i(busy_i), .addr_stb_o(addr_stb_o), .word_stb_o(word_stb_o),
    .data_stb_o(data_stb_o), .rnw_o(rnw_o), .rd_req_o(rd_req_o),
    .stop_o(stop_o)
);

// File: tb/test_tw_mem_slave.sv
module test_tw_mem_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic busy = 1'b0;
    logic [1:0] strap = 2'b10;
    logic [7:0] rd_data = 8'h00;
    logic addr_stb, page, rnw, word_stb, data_stb, rd_req, stop_p;
    logic [7:0] rx_byte;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0;
    int n_addr = 0, n_word = 0, n_data = 0, n_req = 0, n_stop = 0, oe_viol = 0;
    logic [7:0] rx_log [0:15];
    int rx_idx = 0;
    logic oe_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_mem_slave i_tw_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
        .addr_stb_o(addr_stb), .page_o(page), .rnw_o(rnw), .word_stb_o(word_stb),
        .data_stb_o(data_stb), .rx_byte_o(rx_byte), .rd_req_o(rd_req), .stop_o(stop_p)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'hC3 ^ {k[3:0], k[3:0]};
    endfunction

    // bench memory model and strobe monitors
    always @(posedge clk) begin
        if (rd_req) begin
            rd_data <= pat(n_req);
            n_req <= n_req + 1;
        end
        if (addr_stb) n_addr <= n_addr + 1;
        if (word_stb) n_word <= n_word + 1;
        if (data_stb) n_data <= n_data + 1;
        if (stop_p)   n_stop <= n_stop + 1;
        if (word_stb || data_stb) begin
            rx_log[rx_idx[3:0]] <= rx_byte;
            rx_idx <= rx_idx + 1;
        end
        if (sda_oe !== oe_prev && scl_m) oe_viol <= oe_viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QTR);
        scl_m = 1'b1; tick(QTR);
        sda_m = 1'b0; tick(QTR);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(QTR);
        scl_m = 1'b1; tick(QTR);
        sda_m = 1'b1; tick(QTR);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b;    tick(QTR);
        scl_m = 1'b1; tick(QTR);
        r = sda_line; tick(QTR);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, r);
            b = {b[6:0], r};
        end
        bus_bit(~give_ack, r);
    endtask

    task automatic t_reset();
        chk("R1 oe", sda_oe, 0);
        chk("R1 strobes", {addr_stb, word_stb, data_stb, rd_req, stop_p}, 0);
    endtask

    task automatic t_no_start();
        logic ack;
        scl_m = 1'b0; tick(QTR);
        wr_byte(8'hAA, ack);
        chk("R2 no ack", ack, 0);
        chk("R2 no addr strobe", n_addr, 0);
        scl_m = 1'b1; tick(QTR);
    endtask

    task automatic t_write();
        logic ack;
        int s0 = n_stop;
        bus_start();
        wr_byte(8'hAA, ack);
        chk("R3 ack", ack, 1);
        chk("R3 addr strobe", n_addr, 1);
        chk("R3 page bit", page, 1);
        chk("R3 rnw", rnw, 0);
        wr_byte(8'h3C, ack);
        chk("R6 word ack", ack, 1);
        chk("R6 word strobe", n_word, 1);
        chk("R6 word byte", rx_byte, 8'h3C);
        wr_byte(8'h11, ack);
        chk("R6 data ack 1", ack, 1);
        wr_byte(8'h22, ack);
        chk("R6 data ack 2", ack, 1);
        chk("R6 data count", n_data, 2);
        chk("R6 data log 1", rx_log[1], 8'h11);
        chk("R6 data log 2", rx_log[2], 8'h22);
        bus_stop();
        chk("R10 stop pulse", n_stop, s0 + 1);
        chk("R10 released", sda_oe, 0);
    endtask

    task automatic t_mismatch();
        logic ack;
        int a0 = n_addr, s0 = n_stop;
        bus_start();
        wr_byte(8'h9A, ack);
        chk("R4 type mismatch", ack, 0);
        wr_byte(8'h55, ack);
        chk("R4 later byte ignored", ack, 0);
        chk("R4 no word strobe", n_word, 1);
        bus_stop();
        chk("R10 no stop pulse unselected", n_stop, s0);
        bus_start();
        wr_byte(8'hA0, ack);
        chk("R4 strap mismatch", ack, 0);
        chk("R4 no addr strobe", n_addr, a0);
        bus_stop();
    endtask

    task automatic t_busy();
        logic ack;
        int a0 = n_addr;
        busy = 1'b1;
        bus_start();
        wr_byte(8'hA8, ack);
        chk("R5 busy no ack", ack, 0);
        chk("R5 busy no strobe", n_addr, a0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        wr_byte(8'hA8, ack);
        chk("R5 ack after busy", ack, 1);
        chk("R3 page bit 0", page, 0);
        bus_stop();
    endtask

    task automatic t_read_seq();
        logic ack;
        logic [7:0] b;
        int k0 = n_req, s0 = n_stop;
        bus_start();
        wr_byte(8'hAB, ack);
        chk("R3 read ack", ack, 1);
        chk("R3 rnw read", rnw, 1);
        rd_byte(1'b1, b);
        chk("R7 byte 0", b, pat(k0));
        rd_byte(1'b1, b);
        chk("R8 byte 1 after ack", b, pat(k0 + 1));
        rd_byte(1'b0, b);
        chk("R8 byte 2", b, pat(k0 + 2));
        chk("R7 requests", n_req, k0 + 3);
        rd_byte(1'b1, b);
        chk("R8 silent after nack", b, 8'hFF);
        chk("R8 no request after nack", n_req, k0 + 3);
        bus_stop();
        chk("R10 stop after read", n_stop, s0 + 1);
    endtask

    task automatic t_random();
        logic ack;
        logic [7:0] b;
        int k0, w0 = n_word, d0 = n_data;
        bus_start();
        wr_byte(8'hA8, ack);
        wr_byte(8'h07, ack);
        chk("R6 random word ack", ack, 1);
        bus_start();
        k0 = n_req;
        wr_byte(8'hA9, ack);
        chk("R9 restart ack", ack, 1);
        chk("R9 rnw", rnw, 1);
        rd_byte(1'b0, b);
        chk("R9 random byte", b, pat(k0));
        chk("R9 word count", n_word, w0 + 1);
        chk("R9 no data strobe", n_data, d0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        t_reset();
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_no_start();
        t_write();
        t_mismatch();
        t_busy();
        t_read_seq();
        t_random();
        tick(4);
        chk("R11 oe changes while scl high", oe_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule